// File: doc/BRIEF.md
# Three-Phase Dead-Time Gate Controller

This block sits between a controller's PWM outputs and the gate drivers of three external half-bridges. It turns six PWM request lines into six registered gate commands. Two input modes exist. In the six-line mode each gate has its own request line. In the three-line mode, selected automatically whenever all three high-side request lines are held high, one line per phase picks which transistor of that phase conducts. The block never drives both transistors of a phase at once. A programmable dead time separates turning one gate off from turning its partner on.

The block also supervises drain-source comparator flags. A flag counts only while its own gate is on and after a selectable blanking window has passed. A confirmed fault must then persist through a debounce window. Protection faults can latch the bridge off. A supply overvoltage always does so. A regulator overvoltage or a drain-source fault does so only when configured. The latch clears only on an acknowledge strobe from the fault-reporting logic. A low enable input or a low logic-supply-good input forces all gates off for as long as it lasts, without latching. All time values are converted to cycles of the system clock, whose frequency in MHz is a parameter.

Top module: `gate_dt_ctrl`

## Requirements
- R1: After reset all six gate outputs, the bridge-off flag and the drain-source error flag are 0, and the first turn-on after reset needs no dead-time wait.
- R2: In six-line mode (at least one `pwm_hi_i` bit is 0) each gate output follows its own request. It goes high one clock after the request, once the dead time is satisfied, and goes low one clock after the request drops.
- R3: In six-line mode, a phase whose high and low requests are both 1 has both gates driven 0. The two gates of a phase are never 1 together.
- R4: In three-line mode (`pwm_hi_i` = 3'b111), `pwm_lo_i[x]`=1 selects the low-side gate of phase x and `pwm_lo_i[x]`=0 selects the high-side gate, with dead time applied.
- R5: The dead-time code in `dt_code_i` 0..7 means 0, 0.5, 0.75, 1, 1.5, 2, 3 and 6 µs. This is converted to D = ceil(µs·CLK_MHZ) cycles. After a gate turns off, its partner turns on only after max(D,1) cycles in which both gates are 0.
- R6: A comparator bit (`vds_cmp_i` bits 0..2 = high-side gates of phases 0..2, bits 3..5 = low-side gates) is ignored while its gate is off. It is also ignored for B cycles after its gate turns on. The blank code in `blank_code_i` 0..3 means 0.75, 1.5, 3 and 6 µs, converted to B the same way.
- R7: The OR of all qualified comparator bits must hold for 2 µs (G cycles) before `vds_err_o` is set. With the comparator held high, `vds_err_o` rises B+G clocks after the clock on which the gate turned on.
- R8: With `vds_mon_en_i`=0, comparator bits never set `vds_err_o` and never turn the bridge off.
- R9: A drain-source fault latches the bridge off, with gates 0 on the same clock that `vds_err_o` rises, only when `vds_trip_en_i`=1. Otherwise the fault is only reported.
- R10: `vm_ov_i`=1 always latches `bridge_off_o` and forces all gates to 0 one clock later.
- R11: `vreg_ov_i` latches the bridge off only while `vreg_trip_en_i`=1. Otherwise it has no effect on the gates.
- R12: `bridge_off_o` and `vds_err_o` hold until a `frame_ack_i` pulse arrives in a cycle with no active trip source. An acknowledge during an active trip is ignored.
- R13: `enable_i`=0 or `vcc_ok_i`=0 forces all gates to 0 one clock later, for as long as it lasts, without setting `bridge_off_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_hi_i | input | 3 | High-side requests, phases 0..2 |
| pwm_lo_i | input | 3 | Low-side requests, or phase selects in three-line mode |
| enable_i | input | 1 | Bridge enable; 0 forces all gates off |
| vcc_ok_i | input | 1 | Logic supply above sleep level; 0 forces all gates off |
| dt_code_i | input | 3 | Dead-time code |
| blank_code_i | input | 2 | Drain-source blanking code |
| vds_mon_en_i | input | 1 | Drain-source monitoring enable |
| vds_trip_en_i | input | 1 | Drain-source fault latches bridge off |
| vreg_trip_en_i | input | 1 | Regulator overvoltage latches bridge off |
| vds_cmp_i | input | 6 | Per-transistor drain-source comparator flags |
| vm_ov_i | input | 1 | Supply overvoltage |
| vreg_ov_i | input | 1 | Regulator overvoltage |
| frame_ack_i | input | 1 | End-of-frame acknowledge strobe |
| gate_hi_o | output | 3 | High-side gate commands |
| gate_lo_o | output | 3 | Low-side gate commands |
| bridge_off_o | output | 1 | Protection latch: bridge held off |
| vds_err_o | output | 1 | Drain-source fault flag |

## Verification
The bench builds the block with CLK_MHZ = 4, so one quarter microsecond is exactly one cycle. Every dead-time code then maps to 0, 2, 3, 4, 6, 8, 12 or 24 cycles, every blank code to 3, 6, 12 or 24 cycles, and the debounce to 8 cycles. This small scale lets the bench sweep all eight dead-time codes and all four blank codes with exact cycle counts. It also covers the zero-code case, where the one-cycle minimum gap applies.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

  localparam int unsigned DEB_QUS = 8;   // debounce, quarter-us
  localparam int unsigned MAX_QUS = 24;  // longest dead/blank time, quarter-us

  function automatic int unsigned dt_qus(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 4;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 12;
      default: return 24;
    endcase
  endfunction

  function automatic int unsigned blank_qus(input logic [1:0] code);
    case (code)
      2'd0:    return 3;
      2'd1:    return 6;
      2'd2:    return 12;
      default: return 24;
    endcase
  endfunction

  function automatic int unsigned qus_to_cyc(input int unsigned qus, input int unsigned mhz);
    return (qus * mhz + 3) / 4;
  endfunction

endpackage

// File: rtl/gdc_phase.sv
module gdc_phase #(
  parameter int          CW   = 5,
  parameter int unsigned MAXC = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_h_i,
  input  logic          req_l_i,
  input  logic          force_i,
  input  logic [CW-1:0] dt_i,
  output logic          gh_o,
  output logic          gl_o
);

  logic          gh_q, gl_q, gh_d, gl_d, on_ok;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    on_ok = !gh_q && !gl_q && !force_i && (cnt_q >= dt_i);
    gh_d  = (gh_q && req_h_i && !force_i) || (on_ok && req_h_i);
    gl_d  = (gl_q && req_l_i && !force_i) || (on_ok && req_l_i && !req_h_i);
    // cnt counts cycles with both gates off since the last turn-off
    if ((gh_q && !gh_d) || (gl_q && !gl_d))           cnt_d = CW'(1);
    else if (!gh_q && !gl_q && cnt_q != CW'(MAXC))    cnt_d = cnt_q + 1'b1;
    else                                              cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gh_q  <= 1'b0;
      gl_q  <= 1'b0;
      cnt_q <= CW'(MAXC);
    end else begin
      gh_q  <= gh_d;
      gl_q  <= gl_d;
      cnt_q <= cnt_d;
    end
  end

  assign gh_o = gh_q;
  assign gl_o = gl_q;

endmodule

// File: rtl/gdc_vds_mon.sv
module gdc_vds_mon #(
  parameter int          NF  = 6,
  parameter int          CW  = 5,
  parameter int unsigned DEB = 8,
  parameter int          DBW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] gate_i,
  input  logic [NF-1:0] cmp_i,
  input  logic [CW-1:0] blank_i,
  input  logic          mon_en_i,
  output logic          set_o
);

  logic [NF-1:0]  qual;
  logic [DBW-1:0] deb_q;
  logic           any;

  for (genvar k = 0; k < NF; k++) begin : g_fet
    logic [CW-1:0] bcnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              bcnt_q <= '0;
      else if (!gate_i[k])      bcnt_q <= '0;
      else if (bcnt_q < blank_i) bcnt_q <= bcnt_q + 1'b1;
    end
    assign qual[k] = gate_i[k] && cmp_i[k] && (bcnt_q >= blank_i);
  end

  assign any = mon_en_i && (|qual);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          deb_q <= '0;
    else if (!any)                        deb_q <= '0;
    else if (deb_q != DBW'(DEB - 1))      deb_q <= deb_q + 1'b1;
  end

  assign set_o = any && (deb_q == DBW'(DEB - 1));

endmodule

// File: rtl/gdc_trip.sv
module gdc_trip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vm_ov_i,
  input  logic vreg_ov_i,
  input  logic vreg_trip_en_i,
  input  logic vds_set_i,
  input  logic vds_trip_en_i,
  input  logic ack_i,
  output logic trip_now_o,
  output logic bridge_off_o,
  output logic vds_err_o
);

  assign trip_now_o = vm_ov_i || (vreg_ov_i && vreg_trip_en_i) || (vds_set_i && vds_trip_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bridge_off_o <= 1'b0;
      vds_err_o    <= 1'b0;
    end else begin
      if (trip_now_o)  bridge_off_o <= 1'b1;
      else if (ack_i)  bridge_off_o <= 1'b0;
      if (vds_set_i)   vds_err_o <= 1'b1;
      else if (ack_i)  vds_err_o <= 1'b0;
    end
  end

endmodule

// File: rtl/gate_dt_ctrl.sv
module gate_dt_ctrl #(
  parameter int unsigned CLK_MHZ = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] pwm_hi_i,
  input  logic [2:0] pwm_lo_i,
  input  logic       enable_i,
  input  logic       vcc_ok_i,
  input  logic [2:0] dt_code_i,
  input  logic [1:0] blank_code_i,
  input  logic       vds_mon_en_i,
  input  logic       vds_trip_en_i,
  input  logic       vreg_trip_en_i,
  input  logic [5:0] vds_cmp_i,
  input  logic       vm_ov_i,
  input  logic       vreg_ov_i,
  input  logic       frame_ack_i,
  output logic [2:0] gate_hi_o,
  output logic [2:0] gate_lo_o,
  output logic       bridge_off_o,
  output logic       vds_err_o
);
  import gdc_pkg::*;

  localparam int unsigned MAXC = qus_to_cyc(MAX_QUS, CLK_MHZ);
  localparam int          CW   = $clog2(MAXC + 1);
  localparam int unsigned DEB  = qus_to_cyc(DEB_QUS, CLK_MHZ);
  localparam int          DBW  = $clog2(DEB + 1);
  localparam int          NPH  = 3;

  logic [CW-1:0]  dt_cyc, blank_cyc;
  logic           three_in, force_off, trip_now, vds_set;
  logic [NPH-1:0] req_h, req_l;

  assign dt_cyc    = CW'(qus_to_cyc(dt_qus(dt_code_i), CLK_MHZ));
  assign blank_cyc = CW'(qus_to_cyc(blank_qus(blank_code_i), CLK_MHZ));
  assign three_in  = &pwm_hi_i;
  assign force_off = bridge_off_o || trip_now || !enable_i || !vcc_ok_i;

  for (genvar x = 0; x < NPH; x++) begin : g_ph
    assign req_h[x] = three_in ? !pwm_lo_i[x] : (pwm_hi_i[x] && !pwm_lo_i[x]);
    assign req_l[x] = three_in ?  pwm_lo_i[x] : (pwm_lo_i[x] && !pwm_hi_i[x]);

    gdc_phase #(.CW(CW), .MAXC(MAXC)) u_phase (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_h_i (req_h[x]),
      .req_l_i (req_l[x]),
      .force_i (force_off),
      .dt_i    (dt_cyc),
      .gh_o    (gate_hi_o[x]),
      .gl_o    (gate_lo_o[x])
    );
  end

  gdc_vds_mon #(.NF(2 * NPH), .CW(CW), .DEB(DEB), .DBW(DBW)) u_vds (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gate_i   ({gate_lo_o, gate_hi_o}),
    .cmp_i    (vds_cmp_i),
    .blank_i  (blank_cyc),
    .mon_en_i (vds_mon_en_i),
    .set_o    (vds_set)
  );

  gdc_trip u_trip (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .vm_ov_i        (vm_ov_i),
    .vreg_ov_i      (vreg_ov_i),
    .vreg_trip_en_i (vreg_trip_en_i),
    .vds_set_i      (vds_set),
    .vds_trip_en_i  (vds_trip_en_i),
    .ack_i          (frame_ack_i),
    .trip_now_o     (trip_now),
    .bridge_off_o   (bridge_off_o),
    .vds_err_o      (vds_err_o)
  );

endmodule

// File: rtl/gate_dt_ctrl_chk.sv
module gate_dt_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       vm_ov_i,
  input logic       vreg_ov_i,
  input logic       vds_mon_en_i,
  input logic       frame_ack_i,
  input logic [2:0] gate_hi_o,
  input logic [2:0] gate_lo_o,
  input logic       bridge_off_o,
  input logic       vds_err_o
);

  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hi_o & gate_lo_o) == 3'b000);

  for (genvar x = 0; x < 3; x++) begin : g_gap
    p_gap_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gate_lo_o[x]) |-> !$past(gate_hi_o[x]));
    p_gap_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gate_hi_o[x]) |-> !$past(gate_lo_o[x]));
  end

  p_mon_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vds_mon_en_i && !vds_err_o |=> !vds_err_o);

  p_vm_trip_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vm_ov_i |=> bridge_off_o && gate_hi_o == 3'b000 && gate_lo_o == 3'b000);

  p_latch_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bridge_off_o && !frame_ack_i |=> bridge_off_o);

  p_release_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ack_i && !vm_ov_i && !vreg_ov_i && !vds_mon_en_i |=> !bridge_off_o && !vds_err_o);

  p_enable_off_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> gate_hi_o == 3'b000 && gate_lo_o == 3'b000);

endmodule

bind gate_dt_ctrl gate_dt_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .vm_ov_i      (vm_ov_i),
  .vreg_ov_i    (vreg_ov_i),
  .vds_mon_en_i (vds_mon_en_i),
  .frame_ack_i  (frame_ack_i),
  .gate_hi_o    (gate_hi_o),
  .gate_lo_o    (gate_lo_o),
  .bridge_off_o (bridge_off_o),
  .vds_err_o    (vds_err_o)
);

// File: tb/gate_dt_ctrl_tb.sv
`timescale 1ns/1ps
module gate_dt_ctrl_tb;

  localparam int unsigned MHZ = 4;  // 1 cycle = 0.25 us
  localparam int DEB_C = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hi = '0, lo = '0, dt = 3'd3;
  logic [1:0] blk = 2'd2;
  logic       en = 1'b1, vcc = 1'b1, mon_en = 1'b0, vds_trip = 1'b0, vreg_trip = 1'b0;
  logic [5:0] cmp = '0;
  logic       vm_ov = 1'b0, vreg_ov = 1'b0, ack = 1'b0;
  logic [2:0] gh, gl;
  logic       boff, verr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gate_dt_ctrl #(.CLK_MHZ(MHZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_hi_i(hi), .pwm_lo_i(lo),
    .enable_i(en), .vcc_ok_i(vcc), .dt_code_i(dt), .blank_code_i(blk),
    .vds_mon_en_i(mon_en), .vds_trip_en_i(vds_trip), .vreg_trip_en_i(vreg_trip),
    .vds_cmp_i(cmp), .vm_ov_i(vm_ov), .vreg_ov_i(vreg_ov), .frame_ack_i(ack),
    .gate_hi_o(gh), .gate_lo_o(gl), .bridge_off_o(boff), .vds_err_o(verr)
  );

  function automatic int dt_cyc(input int code);
    int q[8] = '{0, 2, 3, 4, 6, 8, 12, 24};
    return q[code];
  endfunction

  function automatic int blank_cyc(input int code);
    int q[4] = '{3, 6, 12, 24};
    return q[code];
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    hi = '0; lo = '0; cmp = '0;
    step(30);
  endtask

  task automatic t_reset();
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 gates", {gh, gl}, 0);
    check("R1 bridge_off", boff, 0);
    check("R1 vds_err", verr, 0);
  endtask

  task automatic t_six();
    hi = 3'b010; lo = 3'b000;
    step(1);
    check("R1 R2 first turn-on immediate", gh, 3'b010);
    lo = 3'b100;
    step(1);
    check("R2 low gate follows", gl, 3'b100);
    hi = 3'b000;
    step(1);
    check("R2 high gate drops", gh, 3'b000);
    idle();
    hi = 3'b010; lo = 3'b010;
    step(1);
    check("R3 both requested", {gh[1], gl[1]}, 0);
    step(5);
    check("R3 both requested held", {gh[1], gl[1]}, 0);
    idle();
  endtask

  task automatic t_dead(input int code);
    int n;
    int exp;
    dt = 3'(code);
    hi = 3'b000; lo = 3'b001;
    step(30);
    check("R2 low on", gl[0], 1);
    hi = 3'b001; lo = 3'b000;
    step(1);
    check("R5 both off after swap", {gh[0], gl[0]}, 0);
    n = 0;
    while (gh[0] == 1'b0 && n < 60) begin
      step(1);
      n++;
    end
    exp = (dt_cyc(code) > 1) ? dt_cyc(code) : 1;
    check($sformatf("R5 dead gap code %0d", code), n, exp);
    idle();
  endtask

  task automatic t_three();
    dt = 3'd1;
    hi = 3'b111; lo = 3'b101;
    step(30);
    check("R4 low select", gl, 3'b101);
    check("R4 high select", gh, 3'b010);
    lo = 3'b010;
    step(1);
    check("R4 R5 all off in gap", {gh, gl}, 0);
    step(2);
    check("R4 high after gap", gh, 3'b101);
    check("R4 low after gap", gl, 3'b010);
    idle();
  endtask

  task automatic t_vds(input int k, input int bcode, input bit trip);
    int n;
    blk = 2'(bcode); mon_en = 1'b1; vds_trip = trip;
    cmp = 6'(1 << k);
    step(30);
    check("R6 comparator on off gate ignored", verr, 0);
    if (k < 3) hi = 3'(1 << k); else lo = 3'(1 << (k - 3));
    step(1);
    check("R6 gate on", {gl, gh}, 1 << k);
    n = 0;
    while (verr == 1'b0 && n < 100) begin
      step(1);
      n++;
    end
    check($sformatf("R6 R7 fet %0d blank %0d set delay", k, bcode), n, blank_cyc(bcode) + DEB_C);
    if (trip) begin
      check("R9 bridge latched", boff, 1);
      check("R9 gates off", {gh, gl}, 0);
    end else begin
      check("R9 report only", boff, 0);
      check("R9 gate stays on", {gl, gh}, 1 << k);
    end
    cmp = '0; hi = '0; lo = '0;
    step(5);
    check("R12 error held", verr, 1);
    check("R12 bridge held", boff, int'(trip));
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    check("R12 error cleared", verr, 0);
    check("R12 bridge cleared", boff, 0);
    mon_en = 1'b0; vds_trip = 1'b0;
    idle();
  endtask

  task automatic t_blank_short();
    // fault shorter than the debounce does not set the flag
    blk = 2'd0; mon_en = 1'b1;
    lo = 3'b010;
    step(10);
    cmp = 6'b010000;
    step(DEB_C - 1);
    cmp = '0;
    step(5);
    check("R7 short fault ignored", verr, 0);
    mon_en = 1'b0;
    idle();
  endtask

  task automatic t_mon_off();
    mon_en = 1'b0; vds_trip = 1'b1;
    cmp = 6'b001000; lo = 3'b001;
    step(60);
    check("R8 no error", verr, 0);
    check("R8 no trip", boff, 0);
    check("R8 gate on", gl[0], 1);
    vds_trip = 1'b0;
    idle();
  endtask

  task automatic t_vm();
    lo = 3'b001;
    step(30);
    vm_ov = 1'b1;
    step(1);
    check("R10 bridge off", boff, 1);
    check("R10 gates off", {gh, gl}, 0);
    vm_ov = 1'b0;
    step(5);
    check("R12 held after fault gone", boff, 1);
    check("R12 gates held off", {gh, gl}, 0);
    vm_ov = 1'b1; ack = 1'b1;
    step(1);
    ack = 1'b0; vm_ov = 1'b0;
    step(3);
    check("R12 ack during trip ignored", boff, 1);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    check("R12 ack releases", boff, 0);
    step(30);
    check("R10 gate recovers", gl[0], 1);
    idle();
  endtask

  task automatic t_vreg();
    lo = 3'b001;
    step(30);
    vreg_trip = 1'b0; vreg_ov = 1'b1;
    step(5);
    check("R11 masked no trip", boff, 0);
    check("R11 masked gate on", gl[0], 1);
    vreg_trip = 1'b1;
    step(1);
    check("R11 enabled trip", boff, 1);
    check("R11 gates off", gl, 0);
    vreg_ov = 1'b0; vreg_trip = 1'b0;
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    check("R11 R12 released", boff, 0);
    idle();
  endtask

  task automatic t_force();
    lo = 3'b001;
    step(30);
    en = 1'b0;
    step(1);
    check("R13 enable low gates off", {gh, gl}, 0);
    check("R13 enable low no latch", boff, 0);
    step(10);
    check("R13 held off", {gh, gl}, 0);
    en = 1'b1;
    step(30);
    check("R13 enable restores", gl[0], 1);
    vcc = 1'b0;
    step(1);
    check("R13 vcc low gates off", {gh, gl}, 0);
    check("R13 vcc low no latch", boff, 0);
    vcc = 1'b1;
    step(30);
    check("R13 vcc restores", gl[0], 1);
    idle();
  endtask

  initial begin
    t_reset();
    t_six();
    for (int c = 0; c < 8; c++) t_dead(c);
    t_three();
    dt = 3'd3;
    for (int b = 0; b < 4; b++) t_vds((b == 3) ? 0 : b + 3, b, 1'b0);
    t_vds(4, 0, 1'b1);
    t_vds(2, 1, 1'b1);
    t_blank_short();
    t_mon_off();
    t_vm();
    t_vreg();
    t_force();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule